// File: doc/BRIEF.md
# DRAM Node Address Normalizer

This block takes a 40-bit physical system address and decides whether one memory node owns it. When the node owns it, the block produces the normalized address that the node's DRAM controller uses for its chip-select compare. The node is described by a base and limit, a memory-hole size, an interleave-enable mask and the node's own interleave select value. All of these arrive as static configuration inputs.

The address first goes through a range check. If the hole size is nonzero, addresses at or above 4 GiB are moved down by the hole size. The node base, taken at 16 MiB granularity, is then subtracted. When node interleaving is on, the interleave bits of the address must match this node's select value, and those bits are removed from the address so that the node sees a dense space. The result is registered in a single pipeline stage. It comes out with a valid strobe, a hit flag and a configuration-error flag.

Top module: `dram_node_norm`

## Requirements
- R1: While reset is asserted and after its release, out_valid, out_hit, out_err and out_addr are all zero until the first valid input is accepted.
- R2: An input presented with in_valid high produces out_valid high on the next clock, together with that input's hit, error and address. A cycle with in_valid low gives out_valid, out_hit and out_err low on the next clock, and out_addr keeps its previous value.
- R3: An address strictly below cfg_base or strictly above cfg_limit gives out_hit = 0. An address equal to either bound is inside the range. The range check uses the address as presented, before hole adjustment.
- R4: When cfg_base and cfg_limit are both zero, every address gives out_hit = 0.
- R5: When cfg_hole is nonzero and the presented address is at or above 0x1_0000_0000, cfg_hole is subtracted from the address before the base subtraction and before the interleave select check. When cfg_hole is zero, or the address is below 0x1_0000_0000, the address is used unchanged.
- R6: The base subtracted is cfg_base with bits [23:0] forced to zero. The low 24 bits of cfg_base have no effect on out_addr.
- R7: The legal values of cfg_ilv_mask are 0, 1, 3 and 7. Any other value gives out_err = 1 and out_hit = 0 for every valid input, whether or not the address is in range.
- R8: Address bits [14:12], after hole adjustment, ANDed with cfg_ilv_mask must equal cfg_ilv_sel. Otherwise out_hit = 0. With mask 0 this reduces to requiring cfg_ilv_sel = 0.
- R9: Let D be the address after hole adjustment minus the base. On a hit, out_addr = {D[35+k:12+k], D[11:0]}, where k is 0, 1, 2 or 3 for masks 0, 1, 3 and 7.
- R10: out_hit and out_err are never high together, and neither is high unless out_valid is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Address qualifier |
| in_addr | input | 40 | Physical system address |
| cfg_base | input | 40 | Lowest address owned by the node |
| cfg_limit | input | 40 | Highest address owned by the node |
| cfg_hole | input | 40 | Memory-hole size, zero when no hole is hoisted |
| cfg_ilv_mask | input | 3 | Interleave-enable mask (0, 1, 3 or 7) |
| cfg_ilv_sel | input | 3 | This node's interleave select value |
| out_valid | output | 1 | Result qualifier, one cycle after in_valid |
| out_hit | output | 1 | The node owns the address |
| out_err | output | 1 | Interleave mask is illegal |
| out_addr | output | 36 | Normalized DRAM controller address |

## Verification
The bench probes both inclusive bounds of the node window and the addresses just outside them. An off-by-one comparator would accept one neighbour or reject one bound. It places addresses on either side of 4 GiB with and without a hole, because a design that tests the adjusted address, or that ignores a zero hole size, would return an address shifted by the hole. It drives each legal interleave mask with matching and mismatching select bits and compares against the expected bit excision. A wrong slice would duplicate or drop one interleave bit in the output. It also feeds illegal masks together with out-of-range addresses, and a non-zero low part of the base. A design that let the range check hide the error, or that subtracted the full base, would show up in out_err or out_addr.

// File: rtl/dnorm_pkg.sv
package dnorm_pkg;

    // Default geometry of the normalizer
    localparam int unsigned DN_ADDR_W   = 40;  // system address width
    localparam int unsigned DN_NORM_W   = 36;  // normalized address width
    localparam int unsigned DN_BASE_LSB = 24;  // base granularity (16 MiB)
    localparam int unsigned DN_IL_LSB   = 12;  // lowest interleave bit
    localparam int unsigned DN_IL_BITS  = 3;   // number of interleave bits
    localparam int unsigned DN_HOLE_BIT = 32;  // hoisting applies from 2**this

    // Outcome of one lookup
    typedef enum logic [1:0] {
        DN_MISS   = 2'd0,
        DN_HIT    = 2'd1,
        DN_CFGERR = 2'd2
    } dn_status_e;

endpackage

// File: rtl/dnorm_window.sv
// Range check, hole hoisting and base removal.
module dnorm_window #(
    parameter int unsigned ADDR_W   = dnorm_pkg::DN_ADDR_W,
    parameter int unsigned DRAM_W   = dnorm_pkg::DN_NORM_W + dnorm_pkg::DN_IL_BITS,
    parameter int unsigned BASE_LSB = dnorm_pkg::DN_BASE_LSB,
    parameter int unsigned HOLE_BIT = dnorm_pkg::DN_HOLE_BIT
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [ADDR_W-1:0] base,
    input  logic [ADDR_W-1:0] limit,
    input  logic [ADDR_W-1:0] hole,
    output logic              in_range,
    output logic [ADDR_W-1:0] adj_addr,
    output logic [DRAM_W-1:0] dram_addr
);

    localparam logic [ADDR_W-1:0] HOLE_START = ADDR_W'(1) << HOLE_BIT;

    logic              node_empty;
    logic              hoist;
    logic [ADDR_W-1:0] base_eff;

    assign node_empty = (base == '0) && (limit == '0);
    assign in_range   = !node_empty && (addr >= base) && (addr <= limit);

    assign hoist    = (hole != '0) && (addr >= HOLE_START);
    assign adj_addr = hoist ? (addr - hole) : addr;

    assign base_eff  = {base[ADDR_W-1:BASE_LSB], {BASE_LSB{1'b0}}};
    assign dram_addr = DRAM_W'(adj_addr - base_eff);

endmodule

// File: rtl/dnorm_ilv.sv
// Interleave mask decode, select compare and bit excision.
module dnorm_ilv #(
    parameter int unsigned NORM_W  = dnorm_pkg::DN_NORM_W,
    parameter int unsigned IL_LSB  = dnorm_pkg::DN_IL_LSB,
    parameter int unsigned IL_BITS = dnorm_pkg::DN_IL_BITS,
    localparam int unsigned DRAM_W = NORM_W + IL_BITS,
    localparam int unsigned HI_W   = NORM_W - IL_LSB
) (
    input  logic [DRAM_W-1:0]  dram_addr,
    input  logic [IL_BITS-1:0] sel_bits,
    input  logic [IL_BITS-1:0] mask,
    input  logic [IL_BITS-1:0] node_sel,
    output logic               mask_ok,
    output logic               sel_ok,
    output logic [NORM_W-1:0]  norm_addr
);

    logic [IL_BITS:0] way_hit;
    logic [NORM_W-1:0] cand [IL_BITS+1];

    // One candidate per legal mask: k low-order ones remove k bits
    for (genvar k = 0; k <= IL_BITS; k++) begin : g_way
        localparam logic [IL_BITS-1:0] PAT = IL_BITS'((1 << k) - 1);
        assign way_hit[k] = (mask == PAT);
        assign cand[k]    = {dram_addr[IL_LSB+k +: HI_W], dram_addr[IL_LSB-1:0]};
    end

    assign mask_ok = |way_hit;
    assign sel_ok  = ((sel_bits & mask) == node_sel);

    always_comb begin
        norm_addr = '0;
        for (int k = 0; k <= IL_BITS; k++) begin
            if (way_hit[k]) begin
                norm_addr = norm_addr | cand[k];
            end
        end
    end

endmodule

// File: rtl/dram_node_norm.sv
// Top: one registered stage around the window and interleave logic.
module dram_node_norm #(
    parameter int unsigned ADDR_W   = dnorm_pkg::DN_ADDR_W,
    parameter int unsigned NORM_W   = dnorm_pkg::DN_NORM_W,
    parameter int unsigned BASE_LSB = dnorm_pkg::DN_BASE_LSB,
    parameter int unsigned IL_LSB   = dnorm_pkg::DN_IL_LSB,
    parameter int unsigned IL_BITS  = dnorm_pkg::DN_IL_BITS,
    parameter int unsigned HOLE_BIT = dnorm_pkg::DN_HOLE_BIT
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               in_valid,
    input  logic [ADDR_W-1:0]  in_addr,
    input  logic [ADDR_W-1:0]  cfg_base,
    input  logic [ADDR_W-1:0]  cfg_limit,
    input  logic [ADDR_W-1:0]  cfg_hole,
    input  logic [IL_BITS-1:0] cfg_ilv_mask,
    input  logic [IL_BITS-1:0] cfg_ilv_sel,
    output logic               out_valid,
    output logic               out_hit,
    output logic               out_err,
    output logic [NORM_W-1:0]  out_addr
);

    import dnorm_pkg::*;

    localparam int unsigned DRAM_W = NORM_W + IL_BITS;

    typedef struct packed {
        logic              vld;
        dn_status_e        st;
        logic [NORM_W-1:0] addr;
    } stage_t;

    logic              in_range;
    logic [ADDR_W-1:0] adj_addr;
    logic [DRAM_W-1:0] dram_addr;
    logic              mask_ok;
    logic              sel_ok;
    logic [NORM_W-1:0] norm_addr;

    stage_t stage_d, stage_q;

    dnorm_window #(
        .ADDR_W  (ADDR_W),
        .DRAM_W  (DRAM_W),
        .BASE_LSB(BASE_LSB),
        .HOLE_BIT(HOLE_BIT)
    ) u_window (
        .addr     (in_addr),
        .base     (cfg_base),
        .limit    (cfg_limit),
        .hole     (cfg_hole),
        .in_range (in_range),
        .adj_addr (adj_addr),
        .dram_addr(dram_addr)
    );

    dnorm_ilv #(
        .NORM_W (NORM_W),
        .IL_LSB (IL_LSB),
        .IL_BITS(IL_BITS)
    ) u_ilv (
        .dram_addr(dram_addr),
        .sel_bits (adj_addr[IL_LSB +: IL_BITS]),
        .mask     (cfg_ilv_mask),
        .node_sel (cfg_ilv_sel),
        .mask_ok  (mask_ok),
        .sel_ok   (sel_ok),
        .norm_addr(norm_addr)
    );

    always_comb begin
        stage_d     = stage_q;
        stage_d.vld = in_valid;
        stage_d.st  = DN_MISS;
        if (in_valid) begin
            stage_d.addr = norm_addr;
            if (!mask_ok) begin
                stage_d.st = DN_CFGERR;
            end else if (in_range && sel_ok) begin
                stage_d.st = DN_HIT;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage_q <= '{vld: 1'b0, st: DN_MISS, addr: '0};
        end else begin
            stage_q <= stage_d;
        end
    end

    assign out_valid = stage_q.vld;
    assign out_hit   = stage_q.vld && (stage_q.st == DN_HIT);
    assign out_err   = stage_q.vld && (stage_q.st == DN_CFGERR);
    assign out_addr  = stage_q.addr;

endmodule

// File: rtl/dram_node_norm_chk.sv
module dram_node_norm_chk #(
    parameter int unsigned ADDR_W  = 40,
    parameter int unsigned NORM_W  = 36,
    parameter int unsigned IL_BITS = 3
) (
    input logic               clk,
    input logic               rst_n,
    input logic               in_valid,
    input logic [ADDR_W-1:0]  in_addr,
    input logic [ADDR_W-1:0]  cfg_base,
    input logic [ADDR_W-1:0]  cfg_limit,
    input logic [IL_BITS-1:0] cfg_ilv_mask,
    input logic               out_valid,
    input logic               out_hit,
    input logic               out_err,
    input logic [NORM_W-1:0]  out_addr
);

    logic mask_legal;
    assign mask_legal = ((cfg_ilv_mask & (cfg_ilv_mask + 1'b1)) == '0);

    a_r2_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    a_r2_idle_follows: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!out_valid && $stable(out_addr)));

    a_r3_below_base: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && (in_addr < cfg_base)) |=> !out_hit);

    a_r3_above_limit: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && (in_addr > cfg_limit)) |=> !out_hit);

    a_r4_empty_node: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && (cfg_base == '0) && (cfg_limit == '0)) |=> !out_hit);

    a_r7_bad_mask: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !mask_legal) |=> (out_err && !out_hit));

    a_r7_good_mask: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && mask_legal) |=> !out_err);

    a_r10_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(out_hit && out_err));

    a_r10_qualified: assert property (@(posedge clk) disable iff (!rst_n)
        (out_hit || out_err) |-> out_valid);

endmodule

bind dram_node_norm dram_node_norm_chk #(
    .ADDR_W (ADDR_W),
    .NORM_W (NORM_W),
    .IL_BITS(IL_BITS)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .in_valid    (in_valid),
    .in_addr     (in_addr),
    .cfg_base    (cfg_base),
    .cfg_limit   (cfg_limit),
    .cfg_ilv_mask(cfg_ilv_mask),
    .out_valid   (out_valid),
    .out_hit     (out_hit),
    .out_err     (out_err),
    .out_addr    (out_addr)
);

// File: tb/dram_node_norm_tb.sv
`timescale 1ns/1ps
module dram_node_norm_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [39:0] in_addr = '0;
    logic [39:0] cfg_base = '0;
    logic [39:0] cfg_limit = '0;
    logic [39:0] cfg_hole = '0;
    logic [2:0]  cfg_ilv_mask = '0;
    logic [2:0]  cfg_ilv_sel = '0;
    logic        out_valid, out_hit, out_err;
    logic [35:0] out_addr;

    int checks = 0;
    int fails  = 0;

    always #10 clk = ~clk;  // 50 MHz

    dram_node_norm u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_addr(in_addr),
        .cfg_base(cfg_base), .cfg_limit(cfg_limit), .cfg_hole(cfg_hole),
        .cfg_ilv_mask(cfg_ilv_mask), .cfg_ilv_sel(cfg_ilv_sel),
        .out_valid(out_valid), .out_hit(out_hit), .out_err(out_err),
        .out_addr(out_addr)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Expected result computed from the requirements
    task automatic model(input logic [39:0] a, output logic h, output logic e,
                         output logic [35:0] n);
        logic [39:0] adj, d;
        logic inr;
        adj = (cfg_hole != 0 && a >= 40'h1_0000_0000) ? a - cfg_hole : a;  // R5
        d   = adj - {cfg_base[39:24], 24'h0};                               // R6
        case (cfg_ilv_mask)                                                 // R9
            3'd1:    n = {d[36:13], d[11:0]};
            3'd3:    n = {d[37:14], d[11:0]};
            3'd7:    n = {d[38:15], d[11:0]};
            default: n = {d[35:12], d[11:0]};
        endcase
        e   = !(cfg_ilv_mask inside {3'd0, 3'd1, 3'd3, 3'd7});              // R7
        inr = !(cfg_base == 0 && cfg_limit == 0) && a >= cfg_base && a <= cfg_limit;
        h   = !e && inr && ((adj[14:12] & cfg_ilv_mask) == cfg_ilv_sel);    // R8
    endtask

    // Drive one address and check the registered result one clock later
    task automatic apply(input string req, input logic [39:0] a);
        logic eh, ee;
        logic [35:0] en;
        @(negedge clk);
        in_valid = 1'b1;
        in_addr  = a;
        model(a, eh, ee, en);
        @(negedge clk);
        in_valid = 1'b0;
        chk({req, " R2 valid"}, 64'(out_valid), 64'(1'b1));
        chk({req, " hit"}, 64'(out_hit), 64'(eh));
        chk({req, " err"}, 64'(out_err), 64'(ee));
        if (eh) chk({req, " addr"}, 64'(out_addr), 64'(en));
    endtask

    task automatic set_cfg(input logic [39:0] b, input logic [39:0] l, input logic [39:0] h,
                           input logic [2:0] m, input logic [2:0] s);
        cfg_base = b; cfg_limit = l; cfg_hole = h; cfg_ilv_mask = m; cfg_ilv_sel = s;
    endtask

    task automatic t_reset();
        chk("R1 valid", 64'(out_valid), 0);
        chk("R1 hit", 64'(out_hit), 0);
        chk("R1 err", 64'(out_err), 0);
        chk("R1 addr", 64'(out_addr), 0);
    endtask

    task automatic t_plain();
        set_cfg(40'h0_4000_0000, 40'h0_7FFF_FFFF, 0, 3'd0, 3'd0);
        apply("R9 plain", 40'h0_4123_4567);
        chk("R9 plain const", 64'(out_addr), 64'h0_0123_4567);
        apply("R9 plain2", 40'h0_7ABC_DEF0);
    endtask

    task automatic t_bounds();
        set_cfg(40'h0_4000_0000, 40'h0_7FFF_FFFF, 0, 3'd0, 3'd0);
        apply("R3 base", 40'h0_4000_0000);
        chk("R3 base hit", 64'(out_hit), 1);
        apply("R3 limit", 40'h0_7FFF_FFFF);
        chk("R3 limit hit", 64'(out_hit), 1);
        apply("R3 below", 40'h0_3FFF_FFFF);
        chk("R3 below miss", 64'(out_hit), 0);
        apply("R3 above", 40'h0_8000_0000);
        chk("R3 above miss", 64'(out_hit), 0);
    endtask

    task automatic t_zero_node();
        set_cfg(0, 0, 0, 3'd0, 3'd0);
        apply("R4 zero", 40'h0);
        chk("R4 zero miss", 64'(out_hit), 0);
    endtask

    task automatic t_hole();
        set_cfg(0, 40'hF_FFFF_FFFF, 40'h0_4000_0000, 3'd0, 3'd0);
        apply("R5 above", 40'h1_2000_0000);
        chk("R5 hoisted", 64'(out_addr), 64'h0_E000_0000);
        apply("R5 below", 40'h0_FFFF_F000);
        chk("R5 not hoisted", 64'(out_addr), 64'h0_FFFF_F000);
        set_cfg(0, 40'hF_FFFF_FFFF, 0, 3'd0, 3'd0);
        apply("R5 nohole", 40'h1_2000_0000);
        chk("R5 nohole addr", 64'(out_addr), 64'h1_2000_0000);
    endtask

    task automatic t_base_low();
        set_cfg(40'h1_0012_3456, 40'hF_FFFF_FFFF, 0, 3'd0, 3'd0);
        apply("R6 lowbase", 40'h1_0050_0000);
        chk("R6 lowbase addr", 64'(out_addr), 64'h0_0050_0000);
    endtask

    task automatic t_interleave();
        set_cfg(0, 40'hF_FFFF_FFFF, 0, 3'd1, 3'd1);
        apply("R8 m1 match", 40'h0_1234_5678);
        apply("R8 m1 miss", 40'h0_1234_4678);
        set_cfg(0, 40'hF_FFFF_FFFF, 0, 3'd3, 3'd2);
        apply("R8 m3 match", 40'h3_ABCD_E678);
        apply("R8 m3 miss", 40'h3_ABCD_F678);
        set_cfg(0, 40'hF_FFFF_FFFF, 0, 3'd7, 3'd5);
        apply("R9 m7 match", 40'h2_3456_D678);
        chk("R9 m7 hit", 64'(out_hit), 1);
        apply("R8 m7 miss", 40'h2_3456_C678);
        chk("R8 m7 miss", 64'(out_hit), 0);
        set_cfg(0, 40'hF_FFFF_FFFF, 0, 3'd0, 3'd1);
        apply("R8 m0 sel", 40'h0_0000_1000);
        chk("R8 m0 sel miss", 64'(out_hit), 0);
    endtask

    task automatic t_badmask();
        for (int m = 0; m < 8; m++) begin
            set_cfg(0, 40'h0_FFFF_FFFF, 0, 3'(m), 3'd0);
            apply("R7 mask", 40'h0_1000_0000);
            apply("R7 mask oor", 40'h5_0000_0000);
        end
        set_cfg(0, 40'h0_FFFF_FFFF, 0, 3'd6, 3'd0);
        apply("R10 excl", 40'h0_2000_0000);
        chk("R10 err only", 64'({out_hit, out_err}), 64'(2'b01));
    endtask

    task automatic t_hold();
        logic [35:0] prev;
        set_cfg(0, 40'hF_FFFF_FFFF, 0, 3'd0, 3'd0);
        apply("R2 hold", 40'h0_0ABC_0123);
        prev = out_addr;
        in_addr = 40'h0_0FFF_FFFF;
        @(negedge clk);
        chk("R2 idle valid", 64'(out_valid), 0);
        chk("R2 idle hit", 64'(out_hit), 0);
        chk("R2 idle addr", 64'(out_addr), 64'(prev));
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_plain();
        t_bounds();
        t_zero_node();
        t_hole();
        t_base_low();
        t_interleave();
        t_badmask();
        t_hold();
        @(negedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule